// File: doc/BRIEF.md
# GNSS Sample Unpack Decimator

This block sits right after the GNSS radio front end. It takes a stream of raw complex baseband samples. Each sample carries a 2-bit in-phase code and a 2-bit quadrature code, and arrives at 16.368 MHz, marked by a valid strobe. The block converts each code to a signed level and applies a carrier rotation that advances a quarter turn on every accepted sample. This removes the quarter-rate carrier using only negations and I/Q swaps.

Each run of four rotated samples is summed, and the sum is delivered as one 4-bit signed I value and one 4-bit signed Q value. The output rate is therefore 4.092 MHz, marked by a one-cycle valid. A tick is raised together with every 4092nd output word, so that downstream buffers can work on one-millisecond frames.

Top module: `gnss_unpack_dec`

## Requirements
- R1: While `rst_n` is low, `out_vld` and `ms_tick` are 0. After reset, `out_i` and `out_q` read 0 until the first output word, and the rotation phase and the group position both restart at zero.
- R2: Each 2-bit code is decoded as sign-magnitude. Bit 1 is the sign and bit 0 selects the magnitude: 00 = +1, 01 = +3, 10 = -1, 11 = -3.
- R3: The rotation phase advances by one on each accepted sample, cycling 0, 1, 2, 3. For decoded values (a, b), the rotated pair is (a, b) at phase 0, (-b, a) at phase 1, (-a, -b) at phase 2 and (b, -a) at phase 3.
- R4: Each output component is the sum of the rotated components of four consecutive accepted samples, clamped to the range -7..+7 and given as a 4-bit two's-complement value.
- R5: `out_vld` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the fourth sample of a group. `out_i` and `out_q` change only when `out_vld` rises.
- R6: Cycles with `in_vld` low are ignored, whatever the data inputs carry. They advance neither the phase nor the group, and they do not change the sum.
- R7: `ms_tick` is high in the same cycle as every 4092nd `out_vld` pulse since reset, and low at all other times.
- R8: A reset in the middle of a group discards the partial sum. The next group starts at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | 2 | In-phase sign-magnitude code |
| in_q | input | 2 | Quadrature sign-magnitude code |
| out_vld | output | 1 | Decimated word strobe |
| out_i | output | 4 | Decimated in-phase value, signed |
| out_q | output | 4 | Decimated quadrature value, signed |
| ms_tick | output | 1 | Millisecond frame tick |

## Verification
The properties assume that `in_vld` and the data codes are known values at every clock edge once reset is released. They also assume that reset is held for at least one edge at start-up, so the output registers begin from zero.

The stimulus drives all inputs on the falling edge and holds them stable across each rising edge. During idle cycles it fills the data inputs with deliberately misleading codes, so that the rule that idle cycles are ignored is actually tested. Reset is applied both at start-up and partway through a group.

// File: rtl/gud_pkg.sv
// Shared types for the sample unpack decimator.
// Assumes a quarter-turn carrier, so four rotation phases.
package gud_pkg;
    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_e;
endpackage

// File: rtl/gud_rotate.sv
// Decodes sign-magnitude I/Q codes and applies the carrier rotation
// for the current phase. Purely combinational.
// Assumes IN_W >= 2: the top bit is the sign, the low bits hold the
// magnitude index m, and the level is 2m+1.
module gud_rotate
    import gud_pkg::*;
#(
    parameter int IN_W  = 2,
    parameter int VAL_W = IN_W + 1
) (
    input  logic [IN_W-1:0]         code_i,
    input  logic [IN_W-1:0]         code_q,
    input  rot_e                    phase,
    output logic signed [VAL_W-1:0] rot_i,
    output logic signed [VAL_W-1:0] rot_q
);
    logic signed [VAL_W-1:0] lvl_i;
    logic signed [VAL_W-1:0] lvl_q;

    // Map a sign-magnitude code onto its odd signed level.
    function automatic logic signed [VAL_W-1:0] decode(input logic [IN_W-1:0] c);
        logic signed [VAL_W-1:0] mag;
        mag = VAL_W'({c[IN_W-2:0], 1'b1});
        return c[IN_W-1] ? -mag : mag;
    endfunction

    // Decode both components.
    always_comb begin
        lvl_i = decode(code_i);
        lvl_q = decode(code_q);
    end

    // Rotate by the phase using swaps and negations only.
    always_comb begin
        unique case (phase)
            ROT_0:   begin rot_i =  lvl_i; rot_q =  lvl_q; end
            ROT_90:  begin rot_i = -lvl_q; rot_q =  lvl_i; end
            ROT_180: begin rot_i = -lvl_i; rot_q = -lvl_q; end
            default: begin rot_i =  lvl_q; rot_q = -lvl_i; end
        endcase
    end
endmodule

// File: rtl/gud_seq.sv
// Tracks the carrier rotation phase and the position inside the
// decimation group. Both advance only on accepted samples.
// Assumes DEC >= 2.
module gud_seq
    import gud_pkg::*;
#(
    parameter int DEC   = 4,
    localparam int POS_W = $clog2(DEC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output rot_e phase,
    output logic last
);
    logic [POS_W-1:0] pos;
    logic [1:0]       ph;

    assign phase = rot_e'(ph);
    assign last  = (pos == POS_W'(DEC - 1));

    // Advance the group position, wrapping after DEC samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (take)
            pos <= last ? '0 : pos + 1'b1;
    end

    // Advance the rotation phase a quarter turn per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= 2'd0;
        else if (take)
            ph <= ph + 2'd1;
    end
endmodule

// File: rtl/gud_accum.sv
// Sums DEC rotated samples per lane (I and Q). At the group's last
// sample it emits a saturated OUT_W-bit word with a one-cycle valid.
// Assumes the accumulator width covers DEC times the largest level.
module gud_accum #(
    parameter int VAL_W = 3,
    parameter int DEC   = 4,
    parameter int OUT_W = 4,
    localparam int ACC_W = VAL_W + $clog2(DEC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    last,
    input  logic signed [VAL_W-1:0] val_i,
    input  logic signed [VAL_W-1:0] val_q,
    output logic                    out_vld,
    output logic [OUT_W-1:0]        out_i,
    output logic [OUT_W-1:0]        out_q
);
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'(2 ** (OUT_W - 1) - 1);

    logic signed [VAL_W-1:0] val [2];
    logic [OUT_W-1:0]        res [2];

    assign val[0] = val_i;
    assign val[1] = val_q;
    assign out_i  = res[0];
    assign out_q  = res[1];

    // Clamp a sum into the symmetric output range.
    function automatic logic [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] s);
        if (s > LIM)
            return LIM[OUT_W-1:0];
        else if (s < -LIM)
            return -LIM[OUT_W-1:0];
        else
            return s[OUT_W-1:0];
    endfunction

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] nxt;

        // Running sum including the current sample.
        assign nxt = acc + ACC_W'(val[ln]);

        // Accumulate, then dump and clear at the group end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc     <= '0;
                res[ln] <= '0;
            end else if (take) begin
                if (last) begin
                    acc     <= '0;
                    res[ln] <= clamp(nxt);
                end else begin
                    acc <= nxt;
                end
            end
        end
    end

    // One-cycle valid pulse for each completed group.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_vld <= 1'b0;
        else
            out_vld <= take && last;
    end
endmodule

// File: rtl/gud_ms.sv
// Counts emitted words and raises a tick in step with every
// MS_OUTS-th word.
// Assumes emit is the pre-register strobe that becomes out_vld.
module gud_ms #(
    parameter int MS_OUTS = 4092,
    localparam int CNT_W  = $clog2(MS_OUTS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    output logic tick
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == CNT_W'(MS_OUTS - 1));

    // Frame counter over emitted words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (emit)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // Tick register, aligned with the output valid.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= 1'b0;
        else
            tick <= emit && wrap;
    end
endmodule

// File: rtl/gnss_unpack_dec.sv
// Top level of the sample unpack decimator: decode and rotate, then
// a four-sample sum, plus a millisecond frame tick.
// Assumes a synchronous active-low reset and inputs that are stable
// around the rising edge.
module gnss_unpack_dec
    import gud_pkg::*;
#(
    parameter int IN_W    = 2,
    parameter int DEC     = 4,
    parameter int OUT_W   = 4,
    parameter int MS_OUTS = 4092
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_i,
    input  logic [IN_W-1:0]  in_q,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_i,
    output logic [OUT_W-1:0] out_q,
    output logic             ms_tick
);
    localparam int VAL_W = IN_W + 1;

    rot_e                    phase;
    logic                    last;
    logic signed [VAL_W-1:0] rot_i;
    logic signed [VAL_W-1:0] rot_q;

    gud_seq #(.DEC(DEC)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (in_vld),
        .phase (phase),
        .last  (last)
    );

    gud_rotate #(.IN_W(IN_W), .VAL_W(VAL_W)) u_rot (
        .code_i (in_i),
        .code_q (in_q),
        .phase  (phase),
        .rot_i  (rot_i),
        .rot_q  (rot_q)
    );

    gud_accum #(.VAL_W(VAL_W), .DEC(DEC), .OUT_W(OUT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (in_vld),
        .last    (last),
        .val_i   (rot_i),
        .val_q   (rot_q),
        .out_vld (out_vld),
        .out_i   (out_i),
        .out_q   (out_q)
    );

    gud_ms #(.MS_OUTS(MS_OUTS)) u_ms (
        .clk   (clk),
        .rst_n (rst_n),
        .emit  (in_vld && last),
        .tick  (ms_tick)
    );
endmodule

// File: rtl/gud_checker.sv
// Port-level properties for the sample unpack decimator, bound to
// the top module.
module gud_checker #(
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q,
    input logic             ms_tick
);
    localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_vld && !ms_tick); // R1
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) out_vld |=> !out_vld); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable({out_i, out_q}) |-> out_vld); // R5
    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n) out_vld |-> (out_i != MOST_NEG) && (out_q != MOST_NEG)); // R4
    AST_VLD_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) out_vld |-> $past(in_vld)); // R6
    AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) ms_tick |-> out_vld); // R7
endmodule

bind gnss_unpack_dec gud_checker #(.OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_i   (out_i),
    .out_q   (out_q),
    .ms_tick (ms_tick)
);

// File: tb/sim_gnss_unpack_dec.sv
// Directed bench for the sample unpack decimator.
module sim_gnss_unpack_dec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [1:0] in_i = 2'b00;
    logic [1:0] in_q = 2'b00;
    logic       out_vld;
    logic [3:0] out_i;
    logic [3:0] out_q;
    logic       ms_tick;

    int total = 0;
    int bad = 0;
    int nsamp = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gnss_unpack_dec u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_i    (in_i),
        .in_q    (in_q),
        .out_vld (out_vld),
        .out_i   (out_i),
        .out_q   (out_q),
        .ms_tick (ms_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model of the code levels, from R2.
    function automatic int lvl(input logic [1:0] c);
        int m;
        m = c[0] ? 3 : 1;
        return c[1] ? -m : m;
    endfunction

    // Expected group result (R3 rotation, R4 sum and clamp).
    function automatic void model(input logic [7:0] ci, input logic [7:0] cq,
                                  input int ph0, output int ei, output int eq);
        int a, b, p;
        ei = 0;
        eq = 0;
        for (int k = 0; k < 4; k++) begin
            a = lvl(ci[2*k +: 2]);
            b = lvl(cq[2*k +: 2]);
            p = (ph0 + k) % 4;
            case (p)
                0: begin ei += a;  eq += b;  end
                1: begin ei += -b; eq += a;  end
                2: begin ei += -a; eq += -b; end
                default: begin ei += b; eq += -a; end
            endcase
        end
        if (ei > 7) ei = 7;
        if (ei < -7) ei = -7;
        if (eq > 7) eq = 7;
        if (eq < -7) eq = -7;
    endfunction

    // Send one group of four samples with idle gaps, then check the result.
    task automatic send_group(input logic [7:0] ci, input logic [7:0] cq,
                              input int gap, input string req);
        int ei, eq;
        model(ci, cq, nsamp % 4, ei, eq);
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_vld = 1'b0;
                in_i = 2'b01;
                in_q = 2'b11;
            end
            @(negedge clk);
            if (k > 0)
                check({req, " R5 no early valid"}, int'(out_vld), 0);
            in_vld = 1'b1;
            in_i = ci[2*k +: 2];
            in_q = cq[2*k +: 2];
            nsamp++;
        end
        @(negedge clk);
        in_vld = 1'b0;
        check({req, " R5 valid"}, int'(out_vld), 1);
        check({req, " I"}, int'($signed(out_i)), ei);
        check({req, " Q"}, int'($signed(out_q)), eq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        nsamp = 0;
        check("R1 valid low in reset", int'(out_vld), 0);
        check("R1 tick low in reset", int'(ms_tick), 0);
        check("R1 I zero", int'(out_i), 0);
        check("R1 Q zero", int'(out_q), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        send_group(8'h00, 8'h00, 0, "R2 all +1");
        send_group(8'h55, 8'h00, 0, "R3 I=+3 Q=+1");
        send_group(8'h1b, 8'he4, 0, "R2 mixed codes");
        send_group(8'hb1, 8'h6c, 0, "R4 positive clamp");
        send_group(8'h1b, 8'hc6, 0, "R4 negative clamp");
    endtask

    task automatic t_gaps();
        send_group(8'h9c, 8'h27, 3, "R6 gaps");
        send_group(8'hb1, 8'h6c, 1, "R6 gaps clamp");
        @(negedge clk);
        check("R6 idle keeps valid low", int'(out_vld), 0);
    endtask

    task automatic t_mid_reset();
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_vld = 1'b1;
            in_i = 2'b01;
            in_q = 2'b01;
        end
        do_reset();
        send_group(8'h55, 8'h00, 0, "R8 after mid reset");
    endtask

    task automatic t_tick();
        int seen = 0;
        int wrong = 0;
        do_reset();
        for (int n = 0; n < 4093; n++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                in_vld = 1'b1;
                in_i = 2'b00;
                in_q = 2'b00;
            end
            @(negedge clk);
            in_vld = 1'b0;
            if (out_vld !== 1'b1) wrong++;
            if (ms_tick) seen++;
            if (int'(ms_tick) != ((n == 4091) ? 1 : 0)) wrong++;
            @(negedge clk);
            if (ms_tick) wrong++;
        end
        check("R7 tick count", seen, 1);
        check("R7 tick position", wrong, 0);
    endtask

    initial begin
        do_reset();
        t_basic();
        t_gaps();
        t_mid_reset();
        t_tick();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++)
            @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule